// File: doc/BRIEF.md
# Watchdog Timer with Paired Clear

This block is a watchdog timer that runs from a slow clock enable. The enable first passes through a power-of-two prescaler and then advances an 8-bit time-out counter. When the counter reaches its terminal count, the block requests a reset. The kind of reset depends on the power state. While the core is running, the block asks for a full chip reset and records the time-out in a status flag. While the core is halted, it asks only for a warm reset, in which the surrounding logic reloads the program counter and stack pointer.

Software keeps the timer from expiring by issuing clear commands. A static mode input picks one of two clearing schemes:

- **Single mode:** one dedicated clear strobe restarts the count.
- **Paired mode:** two distinct commands, A and B, must both arrive, in either order, before the count restarts.

Entering the halt state also restarts the count.

An 8-bit select register sets the prescaler ratio in its low three bits. The upper five bits are plain flag storage for software. The block does not apply resets itself. It only signals which kind is due.

Top module: `wdog_paired_clear`

## Requirements
- R1: While `rst` is high and on the cycle after it, `chip_rst_req`, `warm_rst_req` and `timeout_flag` are 0 and `sel_rdata` reads 0.
- R2: With select field `sel_rdata[2:0]` = s, the counter reaches terminal count after exactly 256·2^s enabled ticks from a restart (code 000 gives 1:1, code 111 gives 1:128).
- R3: The prescaler and counter advance only on cycles where `tick_en` is 1; the other cycles have no effect on the time-out distance.
- R4: A terminal count while `halted` is 0 produces a `chip_rst_req` pulse of exactly one cycle, keeps `warm_rst_req` low, and sets `timeout_flag` in the same cycle.
- R5: A terminal count while `halted` is 1 produces a `warm_rst_req` pulse of exactly one cycle, keeps `chip_rst_req` low, and sets `timeout_flag`.
- R6: When `dual_clr_mode` is 0, a `clr_single` strobe clears both prescaler and counter, and `clr_a` and `clr_b` have no effect.
- R7: When `dual_clr_mode` is 1, the count restarts only once both `clr_a` and `clr_b` have been seen since the last restart, in either order or together; one alone, or `clr_single`, does not restart it.
- R8: In paired mode, the record of a seen A or B command is discarded at every restart, including the restart caused by a terminal count.
- R9: A `halt_enter` strobe restarts prescaler and counter and clears `timeout_flag`.
- R10: Once set, `timeout_flag` stays 1 until reset, halt entry or an effective clear; in paired mode a lone A command does not clear it.
- R11: A write through `sel_we` stores all 8 bits, which read back on `sel_rdata`; bits 7:3 have no effect on the time-out distance.
- R12: A restart arriving on the same cycle as the terminal count wins: no reset request is issued and the full time-out distance starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | External reset, synchronous, active high |
| tick_en | input | 1 | Slow watchdog clock enable |
| dual_clr_mode | input | 1 | 0: single clear command, 1: paired A/B clear |
| clr_single | input | 1 | Single clear command strobe |
| clr_a | input | 1 | First paired clear command strobe |
| clr_b | input | 1 | Second paired clear command strobe |
| halt_enter | input | 1 | Halt-entry strobe |
| halted | input | 1 | Core is in the halted power state |
| sel_we | input | 1 | Select register write enable |
| sel_wdata | input | 8 | Select register write data |
| sel_rdata | output | 8 | Select register contents |
| chip_rst_req | output | 1 | One-cycle full chip reset request |
| warm_rst_req | output | 1 | One-cycle warm reset request (PC and SP only) |
| timeout_flag | output | 1 | Time-out status flag |

## Verification
The bound checker watches the rules that hold on every cycle:

- the two requests never occur together, and each lasts a single cycle;
- a chip request always comes with the status flag, and a warm request only while halted;
- a halt entry, a single-mode clear or a simultaneous A+B clear leaves no request and no flag on the next cycle.

The time-out distance for each prescaler code, the effect of gaps in the enable, and the A/B bookkeeping across restarts can only be shown by the bench's scenarios. The same applies to the ignored commands in each mode and the clear-versus-terminal-count race. Each of these scenarios counts cycles up to the request.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int WD_CNT_W = 8;
    localparam int WD_SEL_W = 3;
    localparam int WD_REG_W = 8;

    typedef enum logic {
        CLR_SINGLE = 1'b0,
        CLR_PAIRED = 1'b1
    } wd_clr_mode_e;

    typedef enum logic [1:0] {
        WD_EV_NONE = 2'd0,
        WD_EV_CHIP = 2'd1,
        WD_EV_WARM = 2'd2
    } wd_event_e;

    typedef struct packed {
        logic single;
        logic part_a;
        logic part_b;
        logic halt;
    } wd_cmd_t;

    // Prescaler stages needed for the largest ratio a select field can pick.
    function automatic int wd_pre_bits(input int sel_w);
        return (1 << sel_w) - 1;
    endfunction

endpackage

// File: rtl/wdog_sel_reg.sv
module wdog_sel_reg #(
    parameter int REG_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic [SEL_W-1:0] sel
);
    logic [REG_W-1:0] store_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
        end else if (we) begin
            store_q <= wdata;
        end
    end

    assign rdata = store_q;
    // Only the low field steers the prescaler; the rest is software storage.
    assign sel   = store_q[SEL_W-1:0];
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int SEL_W = 3,
    parameter int PRE_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick_en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick_o
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    // Low 'sel' bits set: ratio 2^sel.
    assign mask   = ~({PRE_W{1'b1}} << sel);
    assign tick_o = tick_en && ((pre_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_q <= '0;
        end else if (tick_en) begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdog_clear_qual.sv
module wdog_clear_qual
    import wdog_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  wd_clr_mode_e mode,
    input  wd_cmd_t      cmd,
    input  logic         overflow,
    output logic         eff_clear,
    output logic         restart
);
    logic seen_a_q;
    logic seen_b_q;
    logic paired_done;

    assign paired_done = (seen_a_q || cmd.part_a) && (seen_b_q || cmd.part_b);

    always_comb begin
        unique case (mode)
            CLR_SINGLE: eff_clear = cmd.single;
            CLR_PAIRED: eff_clear = paired_done;
            default:    eff_clear = 1'b0;
        endcase
    end

    assign restart = eff_clear || cmd.halt;

    always_ff @(posedge clk) begin
        if (rst || restart || overflow || (mode == CLR_SINGLE)) begin
            seen_a_q <= 1'b0;
            seen_b_q <= 1'b0;
        end else begin
            seen_a_q <= seen_a_q || cmd.part_a;
            seen_b_q <= seen_b_q || cmd.part_b;
        end
    end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic tick,
    input  logic halted,
    output logic overflow_o,
    output logic chip_req_o,
    output logic warm_req_o,
    output logic flag_o
);
    localparam logic [CNT_W-1:0] TERM = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    wd_event_e        ev_d;
    wd_event_e        ev_q;
    logic             flag_q;

    assign overflow_o = tick && (cnt_q == TERM) && !restart;

    always_comb begin
        if (!overflow_o)  ev_d = WD_EV_NONE;
        else if (halted)  ev_d = WD_EV_WARM;
        else              ev_d = WD_EV_CHIP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            ev_q   <= WD_EV_NONE;
            flag_q <= 1'b0;
        end else begin
            ev_q <= ev_d;
            if (restart) begin
                cnt_q  <= '0;
                flag_q <= 1'b0;
            end else if (tick) begin
                cnt_q <= overflow_o ? '0 : cnt_q + 1'b1;
                if (overflow_o) flag_q <= 1'b1;
            end
        end
    end

    assign chip_req_o = (ev_q == WD_EV_CHIP);
    assign warm_req_o = (ev_q == WD_EV_WARM);
    assign flag_o     = flag_q;
endmodule

// File: rtl/wdog_paired_clear.sv
module wdog_paired_clear
    import wdog_pkg::*;
#(
    parameter int CNT_W = WD_CNT_W,
    parameter int SEL_W = WD_SEL_W,
    parameter int REG_W = WD_REG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             dual_clr_mode,
    input  logic             clr_single,
    input  logic             clr_a,
    input  logic             clr_b,
    input  logic             halt_enter,
    input  logic             halted,
    input  logic             sel_we,
    input  logic [REG_W-1:0] sel_wdata,
    output logic [REG_W-1:0] sel_rdata,
    output logic             chip_rst_req,
    output logic             warm_rst_req,
    output logic             timeout_flag
);
    localparam int PRE_W = wd_pre_bits(SEL_W);

    logic [SEL_W-1:0] sel;
    logic             pre_tick;
    logic             eff_clear;
    logic             restart;
    logic             overflow;
    wd_cmd_t          cmd;
    wd_clr_mode_e     mode;

    assign cmd  = '{single: clr_single, part_a: clr_a, part_b: clr_b, halt: halt_enter};
    assign mode = wd_clr_mode_e'(dual_clr_mode);

    wdog_sel_reg #(.REG_W(REG_W), .SEL_W(SEL_W)) u_sel (
        .clk(clk), .rst(rst), .we(sel_we), .wdata(sel_wdata),
        .rdata(sel_rdata), .sel(sel)
    );

    wdog_clear_qual u_qual (
        .clk(clk), .rst(rst), .mode(mode), .cmd(cmd), .overflow(overflow),
        .eff_clear(eff_clear), .restart(restart)
    );

    wdog_prescaler #(.SEL_W(SEL_W), .PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst(rst), .restart(restart), .tick_en(tick_en),
        .sel(sel), .tick_o(pre_tick)
    );

    wdog_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .restart(restart), .tick(pre_tick),
        .halted(halted), .overflow_o(overflow), .chip_req_o(chip_rst_req),
        .warm_req_o(warm_rst_req), .flag_o(timeout_flag)
    );
endmodule

// File: rtl/wdog_paired_clear_chk.sv
module wdog_paired_clear_chk (
    input logic clk,
    input logic rst,
    input logic dual_clr_mode,
    input logic clr_single,
    input logic clr_a,
    input logic clr_b,
    input logic halt_enter,
    input logic halted,
    input logic chip_rst_req,
    input logic warm_rst_req,
    input logic timeout_flag
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !chip_rst_req && !warm_rst_req && !timeout_flag);

    a_r4_chip_pulse_one: assert property (@(posedge clk) disable iff (rst)
        chip_rst_req |=> !chip_rst_req);

    a_r4_chip_sets_flag: assert property (@(posedge clk) disable iff (rst)
        chip_rst_req |-> timeout_flag && !warm_rst_req);

    a_r5_warm_pulse_one: assert property (@(posedge clk) disable iff (rst)
        warm_rst_req |=> !warm_rst_req);

    a_r5_warm_when_halted: assert property (@(posedge clk) disable iff (rst)
        warm_rst_req |-> $past(halted));

    a_r6_single_clears: assert property (@(posedge clk) disable iff (rst)
        (!dual_clr_mode && clr_single) |=> !chip_rst_req && !warm_rst_req && !timeout_flag);

    a_r7_pair_clears: assert property (@(posedge clk) disable iff (rst)
        (dual_clr_mode && clr_a && clr_b) |=> !chip_rst_req && !warm_rst_req && !timeout_flag);

    a_r9_halt_restarts: assert property (@(posedge clk) disable iff (rst)
        halt_enter |=> !chip_rst_req && !warm_rst_req && !timeout_flag);
endmodule

bind wdog_paired_clear wdog_paired_clear_chk u_chk (
    .clk(clk), .rst(rst), .dual_clr_mode(dual_clr_mode), .clr_single(clr_single),
    .clr_a(clr_a), .clr_b(clr_b), .halt_enter(halt_enter), .halted(halted),
    .chip_rst_req(chip_rst_req), .warm_rst_req(warm_rst_req), .timeout_flag(timeout_flag)
);

// File: tb/tb_wdog_paired_clear.sv
module tb_wdog_paired_clear;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       dual_clr_mode = 1'b0;
    logic       clr_single = 1'b0;
    logic       clr_a = 1'b0;
    logic       clr_b = 1'b0;
    logic       halt_enter = 1'b0;
    logic       halted = 1'b0;
    logic       sel_we = 1'b0;
    logic [7:0] sel_wdata = 8'h00;
    logic [7:0] sel_rdata;
    logic       chip_rst_req;
    logic       warm_rst_req;
    logic       timeout_flag;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_paired_clear dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .dual_clr_mode(dual_clr_mode),
        .clr_single(clr_single), .clr_a(clr_a), .clr_b(clr_b),
        .halt_enter(halt_enter), .halted(halted), .sel_we(sel_we),
        .sel_wdata(sel_wdata), .sel_rdata(sel_rdata), .chip_rst_req(chip_rst_req),
        .warm_rst_req(warm_rst_req), .timeout_flag(timeout_flag)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input bit mode);
        @(negedge clk);
        rst = 1'b1; tick_en = 0; clr_single = 0; clr_a = 0; clr_b = 0;
        halt_enter = 0; halted = 0; sel_we = 0; dual_clr_mode = mode;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_sel(input logic [7:0] v);
        @(negedge clk);
        sel_we = 1'b1; sel_wdata = v;
        @(negedge clk);
        sel_we = 1'b0;
    endtask

    // Edges are numbered from 1; a strobe given for edge i is applied before it.
    task automatic run(input int s_at, input int a_at, input int a_at2, input int b_at,
                       input int h_at, input int div, input int max,
                       output int hit, output bit was_warm);
        hit = 0; was_warm = 0;
        for (int i = 1; i <= max; i++) begin
            @(negedge clk);
            clr_single = (i == s_at);
            clr_a      = (i == a_at) || (i == a_at2);
            clr_b      = (i == b_at);
            halt_enter = (i == h_at);
            tick_en    = ((i % div) == 0);
            @(posedge clk); #1;
            if (chip_rst_req || warm_rst_req) begin
                hit = i; was_warm = warm_rst_req;
                break;
            end
        end
        @(negedge clk);
        clr_single = 0; clr_a = 0; clr_b = 0; halt_enter = 0; tick_en = 0;
    endtask

    task automatic strobe(input bit s, input bit a, input bit b, input bit h);
        @(negedge clk);
        clr_single = s; clr_a = a; clr_b = b; halt_enter = h;
        @(negedge clk);
        clr_single = 0; clr_a = 0; clr_b = 0; halt_enter = 0;
    endtask

    task automatic t_reset;
        @(posedge clk); #1;
        check("R1", "chip_rst_req in reset", chip_rst_req, 0);
        check("R1", "warm_rst_req in reset", warm_rst_req, 0);
        check("R1", "timeout_flag in reset", timeout_flag, 0);
        check("R1", "sel_rdata in reset", sel_rdata, 0);
    endtask

    task automatic t_ratio(input int s);
        int hit; bit w;
        do_reset(0);
        write_sel(8'(s));
        run(0, 0, 0, 0, 0, 1, (256 << s) + 8, hit, w);
        check("R2", $sformatf("distance for code %0d", s), hit, 256 << s);
        check("R4", "chip request not warm", w, 0);
    endtask

    task automatic t_normal_overflow;
        int hit; bit w;
        do_reset(0);
        run(0, 0, 0, 0, 0, 1, 300, hit, w);
        check("R4", "flag with pulse", timeout_flag, 1);
        @(posedge clk); #1;
        check("R4", "chip pulse one cycle", chip_rst_req, 0);
        repeat (20) @(posedge clk); #1;
        check("R10", "flag held", timeout_flag, 1);
    endtask

    task automatic t_half_rate;
        int hit; bit w;
        do_reset(0);
        write_sel(8'd1);
        run(0, 0, 0, 0, 0, 2, 1100, hit, w);
        check("R3", "half-rate enable distance", hit, 1024);
    endtask

    task automatic t_halted;
        int hit; bit w;
        do_reset(0);
        halted = 1'b1;
        run(0, 0, 0, 0, 0, 1, 300, hit, w);
        check("R5", "halted distance", hit, 256);
        check("R5", "warm request", w, 1);
        check("R5", "no chip request", chip_rst_req, 0);
        check("R5", "flag set", timeout_flag, 1);
        @(posedge clk); #1;
        check("R5", "warm pulse one cycle", warm_rst_req, 0);
        halted = 1'b0;
    endtask

    task automatic t_single;
        int hit; bit w;
        do_reset(0);
        write_sel(8'd3);
        run(5, 0, 0, 0, 0, 1, 2100, hit, w);
        check("R6", "single clear restarts prescaler", hit, 5 + 2048);
        do_reset(0);
        run(0, 100, 0, 200, 0, 1, 300, hit, w);
        check("R6", "A/B ignored in single mode", hit, 256);
        do_reset(0);
        run(256, 0, 0, 0, 0, 1, 600, hit, w);
        check("R12", "clear on terminal count wins", hit, 512);
    endtask

    task automatic t_dual;
        int hit; bit w;
        do_reset(1);
        run(0, 50, 150, 0, 0, 1, 300, hit, w);
        check("R7", "A alone does not restart", hit, 256);
        do_reset(1);
        run(0, 50, 0, 120, 0, 1, 400, hit, w);
        check("R7", "A then B restarts", hit, 376);
        do_reset(1);
        run(0, 90, 0, 40, 0, 1, 400, hit, w);
        check("R7", "B then A restarts", hit, 346);
        do_reset(1);
        run(0, 60, 0, 60, 0, 1, 400, hit, w);
        check("R7", "A and B together restart", hit, 316);
        do_reset(1);
        run(100, 0, 0, 0, 0, 1, 300, hit, w);
        check("R7", "single ignored in paired mode", hit, 256);
        do_reset(1);
        run(0, 50, 0, 0, 0, 1, 300, hit, w);
        run(0, 0, 0, 44, 0, 1, 300, hit, w);
        check("R8", "seen A dropped at overflow", hit, 256);
    endtask

    task automatic t_flag_clear;
        int hit; bit w;
        do_reset(1);
        run(0, 0, 0, 0, 0, 1, 300, hit, w);
        strobe(0, 1, 0, 0);
        check("R10", "lone A keeps flag", timeout_flag, 1);
        strobe(0, 0, 1, 0);
        check("R10", "pair completion clears flag", timeout_flag, 0);
        do_reset(0);
        run(0, 0, 0, 0, 0, 1, 300, hit, w);
        strobe(1, 0, 0, 0);
        check("R10", "single clear clears flag", timeout_flag, 0);
    endtask

    task automatic t_halt;
        int hit; bit w;
        do_reset(0);
        run(0, 0, 0, 0, 80, 1, 400, hit, w);
        check("R9", "halt entry restarts", hit, 336);
        strobe(0, 0, 0, 1);
        check("R9", "halt entry clears flag", timeout_flag, 0);
    endtask

    task automatic t_user_bits;
        int hit; bit w;
        do_reset(0);
        write_sel(8'hF8);
        @(posedge clk); #1;
        check("R11", "readback", sel_rdata, 8'hF8);
        run(0, 0, 0, 0, 0, 1, 300, hit, w);
        check("R11", "upper bits no effect", hit, 256);
    endtask

    initial begin
        t_reset();
        t_ratio(0);
        t_ratio(1);
        t_ratio(3);
        t_ratio(7);
        t_normal_overflow();
        t_half_rate();
        t_halted();
        t_single();
        t_dual();
        t_flag_clear();
        t_halt();
        t_user_bits();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule